// File: doc/BRIEF.md
# Multichannel Digital Window Comparator

This block watches a stream of 12-bit straight-binary conversion results, each tagged with a channel number from zero to seven. Every channel has its own high threshold, low threshold, hysteresis and consecutive-sample count. A channel raises a high-event flag or a low-event flag once its limits have been violated on enough consecutive samples of that channel. The flags stay set until software clears them.

By default a channel reports values outside the window. A per-channel region bit turns this around, so that the channel reports values inside the window. A per-channel mask chooses which flags reach the alert output. The flags themselves are set whatever the mask holds. The alert output is active low and drives either open-drain or push-pull.

Configuration goes through a simple register port. A write takes effect at the clock edge on which it is presented. A read returns the addressed register one cycle after the address is presented.

Top module: `wincmp_monitor`

## Requirements
- R1: After reset, every channel has high threshold 0xFFF, low threshold 0x000, hysteresis 0 and count 0. Every flag is clear, the read port returns 0, and the alert output is released (alert_oe=0, alert_o=0).
- R2: While the enable bit (bit 0 of control register 0x00) is 0, no sample sets any flag and every consecutive-sample counter is cleared.
- R3: Each channel c has its own four registers at 0x20+4c, in this order: +0 hysteresis, +1 high threshold, +2 count (4 bits), +3 low threshold. Each register reads back what was last written to it.
- R4: With count N, a flag is set on the (N+1)-th consecutive violating sample of that channel. A non-violating sample of that channel restarts the run. Samples of other channels do not affect the run.
- R5: Outside the window, a sample above the high threshold violates the high side and a sample below the low threshold violates the low side. Each side has its own flag: the high flags are at 0x04 and the low flags at 0x05, with bit c for channel c.
- R6: Once a side is violating, it keeps violating as long as the code stays at or above the high threshold minus the hysteresis (high side), or at or below the low threshold plus the hysteresis (low side).
- R7: One cycle after any flag that is set and enabled in the alert mask (register 0x01, bit c), the alert is active. It is idle once no such flag remains.
- R8: A flag is set whether or not its channel is enabled in the alert mask.
- R9: Flags are sticky. Writing 1 to a bit of 0x04 or 0x05 clears that flag. A set in the same cycle wins over the clear.
- R10: When bit 1 of 0x00 is 0 (open-drain), an active alert gives alert_oe=1 and alert_o=0, and an idle alert gives alert_oe=0 and alert_o=0. When the bit is 1 (push-pull), alert_oe=1 and alert_o is 0 while active and 1 while idle.
- R11: When the region bit of a channel (register 0x02, bit c) is 1, a sample counts as a violation if low ≤ code ≤ high. Such a run sets both the high flag and the low flag of that channel.
- R12: With the reset thresholds and out-of-window detection, no code from 0x000 to 0xFFF sets a flag.
- R13: Register 0x06 reads the OR of the high flags and the low flags, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Conversion result present this cycle |
| s_chan | input | 3 | Channel of the result |
| s_code | input | 12 | Result code, straight binary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Registered read data |
| alert_o | output | 1 | Alert level, active low |
| alert_oe | output | 1 | Alert output enable |

## Verification
The hardest state to reach from the ports is a side that is already violating and then sits inside its hysteresis band. The flag may only be set there if the earlier sample was a violation, so the stimulus programs a count of one and sends one sample beyond the threshold, followed by one sample in the band. A second channel with the same threshold but no hysteresis receives the same pair and must stay clear. A second case is the cycle in which a clear write and a setting sample coincide; the bench presents both in the same cycle. A behavioural model in the bench predicts the read data and the alert pins on every clock.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  // Register addresses of the comparator
  localparam int ADR_CTRL   = 'h00;  // bit0 enable, bit1 push-pull alert
  localparam int ADR_AMASK  = 'h01;  // alert channel mask
  localparam int ADR_REGION = 'h02;  // 1 = in-band detection
  localparam int ADR_FHI    = 'h04;  // high flags, write 1 to clear
  localparam int ADR_FLO    = 'h05;  // low flags, write 1 to clear
  localparam int ADR_FANY   = 'h06;  // OR of both, read only
  localparam int ADR_CHBASE = 'h20;  // per-channel block, stride 4

  typedef enum logic [1:0] {
    FLD_HYST  = 2'd0,
    FLD_HIGH  = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_LOW   = 2'd3
  } chfield_e;
endpackage

// File: rtl/wcmp_regs.sv
module wcmp_regs
  import wcmp_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 12,
  parameter int CNTW = 4,
  parameter int AW   = 8,
  parameter int RW   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [RW-1:0]             wr_data,
  input  logic [AW-1:0]             rd_addr,
  output logic [RW-1:0]             rd_data,
  input  logic [NCH-1:0]            flag_hi,
  input  logic [NCH-1:0]            flag_lo,
  output logic                      en,
  output logic                      pp_mode,
  output logic [NCH-1:0]            amask,
  output logic [NCH-1:0]            region,
  output logic [NCH-1:0][DW-1:0]    hyst,
  output logic [NCH-1:0][DW-1:0]    hi_th,
  output logic [NCH-1:0][DW-1:0]    lo_th,
  output logic [NCH-1:0][CNTW-1:0]  evcnt,
  output logic [NCH-1:0]            clr_hi,
  output logic [NCH-1:0]            clr_lo
);
  localparam int CHW   = $clog2(NCH);
  localparam int CHEND = ADR_CHBASE + 4 * NCH;

  logic [AW-1:0]  w_off, r_off;
  logic [CHW-1:0] w_ch, r_ch;
  logic           w_in, r_in;
  chfield_e       w_fld, r_fld;
  logic [RW-1:0]  rb;

  assign w_off = wr_addr - AW'(ADR_CHBASE);
  assign r_off = rd_addr - AW'(ADR_CHBASE);
  assign w_ch  = w_off[CHW+1:2];
  assign r_ch  = r_off[CHW+1:2];
  assign w_fld = chfield_e'(w_off[1:0]);
  assign r_fld = chfield_e'(r_off[1:0]);
  assign w_in  = (wr_addr >= AW'(ADR_CHBASE)) && (wr_addr < AW'(CHEND));
  assign r_in  = (rd_addr >= AW'(ADR_CHBASE)) && (rd_addr < AW'(CHEND));

  assign clr_hi = (wr_en && wr_addr == AW'(ADR_FHI)) ? wr_data[NCH-1:0] : '0;
  assign clr_lo = (wr_en && wr_addr == AW'(ADR_FLO)) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      pp_mode <= 1'b0;
      amask   <= '0;
      region  <= '0;
      hyst    <= '0;
      hi_th   <= '1;
      lo_th   <= '0;
      evcnt   <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL)) begin
        en      <= wr_data[0];
        pp_mode <= wr_data[1];
      end else if (wr_addr == AW'(ADR_AMASK)) begin
        amask <= wr_data[NCH-1:0];
      end else if (wr_addr == AW'(ADR_REGION)) begin
        region <= wr_data[NCH-1:0];
      end else if (w_in) begin
        case (w_fld)
          FLD_HYST:  hyst[w_ch]  <= wr_data[DW-1:0];
          FLD_HIGH:  hi_th[w_ch] <= wr_data[DW-1:0];
          FLD_COUNT: evcnt[w_ch] <= wr_data[CNTW-1:0];
          default:   lo_th[w_ch] <= wr_data[DW-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rb = '0;
    if (rd_addr == AW'(ADR_CTRL))        rb[1:0] = {pp_mode, en};
    else if (rd_addr == AW'(ADR_AMASK))  rb[NCH-1:0] = amask;
    else if (rd_addr == AW'(ADR_REGION)) rb[NCH-1:0] = region;
    else if (rd_addr == AW'(ADR_FHI))    rb[NCH-1:0] = flag_hi;
    else if (rd_addr == AW'(ADR_FLO))    rb[NCH-1:0] = flag_lo;
    else if (rd_addr == AW'(ADR_FANY))   rb[NCH-1:0] = flag_hi | flag_lo;
    else if (r_in) begin
      case (r_fld)
        FLD_HYST:  rb[DW-1:0]   = hyst[r_ch];
        FLD_HIGH:  rb[DW-1:0]   = hi_th[r_ch];
        FLD_COUNT: rb[CNTW-1:0] = evcnt[r_ch];
        default:   rb[DW-1:0]   = lo_th[r_ch];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rb;
  end

  // R3: a write to the high-threshold field of channel 0 lands in that channel
  assert_wr_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(ADR_CHBASE + 1)) |=> hi_th[0] == $past(wr_data[DW-1:0]));
endmodule

// File: rtl/wcmp_chan.sv
module wcmp_chan #(
  parameter int DW   = 12,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            hit,
  input  logic [DW-1:0]   code,
  input  logic [DW-1:0]   hi_th,
  input  logic [DW-1:0]   lo_th,
  input  logic [DW-1:0]   hyst,
  input  logic [CNTW-1:0] evcnt,
  input  logic            inband,
  input  logic            clr_hi,
  input  logic            clr_lo,
  output logic            flag_hi,
  output logic            flag_lo
);
  localparam logic [CNTW-1:0] CMAX = '1;

  logic [CNTW-1:0] cnt_h, cnt_l;
  logic            act_h, act_l, band, viol_h, viol_l, set_h, set_l;
  logic [DW:0]     sum_h, sum_l;

  // A side is already violating when its previous sample was a violation
  assign act_h = (cnt_h != '0);
  assign act_l = (cnt_l != '0);
  assign sum_h = {1'b0, code} + {1'b0, hyst};
  assign sum_l = {1'b0, lo_th} + {1'b0, hyst};
  assign band  = (code >= lo_th) && (code <= hi_th);

  assign viol_h = inband ? band :
                  (act_h ? (sum_h >= {1'b0, hi_th}) : (code > hi_th));
  assign viol_l = inband ? band :
                  (act_l ? ({1'b0, code} <= sum_l) : (code < lo_th));

  assign set_h = en && hit && viol_h && (cnt_h >= evcnt);
  assign set_l = en && hit && viol_l && (cnt_l >= evcnt);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_h <= '0;
      cnt_l <= '0;
    end else if (hit) begin
      cnt_h <= viol_h ? ((cnt_h == CMAX) ? CMAX : cnt_h + 1'b1) : '0;
      cnt_l <= viol_l ? ((cnt_l == CMAX) ? CMAX : cnt_l + 1'b1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else begin
      flag_hi <= set_h | (flag_hi & ~clr_hi);
      flag_lo <= set_l | (flag_lo & ~clr_lo);
    end
  end

  assert_flag_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_hi) || $rose(flag_lo)) |-> ($past(en) && $past(hit)));
  assert_flag_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_hi) |-> ($past(cnt_h) >= $past(evcnt)));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && !clr_hi) |=> flag_hi);
endmodule

// File: rtl/wcmp_alert.sv
module wcmp_alert #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flags_any,
  input  logic [NCH-1:0] amask,
  input  logic           pp_mode,
  output logic           alert_o,
  output logic           alert_oe
);
  logic active;
  assign active = |(flags_any & amask);

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_o  <= 1'b0;
      alert_oe <= 1'b0;
    end else if (pp_mode) begin
      alert_oe <= 1'b1;
      alert_o  <= ~active;
    end else begin
      alert_oe <= active;
      alert_o  <= 1'b0;
    end
  end

  assert_od_release_R10: assert property (@(posedge clk) disable iff (rst)
    !alert_oe |-> !alert_o);
  assert_pp_drives_R10: assert property (@(posedge clk) disable iff (rst)
    $past(pp_mode) |-> alert_oe);
  assert_alert_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (alert_oe && !alert_o) |-> $past(|(flags_any & amask)));
endmodule

// File: rtl/wincmp_monitor.sv
module wincmp_monitor #(
  parameter int NCH  = 8,
  parameter int DW   = 12,
  parameter int CNTW = 4,
  parameter int AW   = 8,
  parameter int RW   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s_valid,
  input  logic [$clog2(NCH)-1:0] s_chan,
  input  logic [DW-1:0]          s_code,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [RW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [RW-1:0]          rd_data,
  output logic                   alert_o,
  output logic                   alert_oe
);
  localparam int CHW = $clog2(NCH);

  logic                     en, pp_mode;
  logic [NCH-1:0]           amask, region, clr_hi, clr_lo, flag_hi, flag_lo;
  logic [NCH-1:0][DW-1:0]   hyst, hi_th, lo_th;
  logic [NCH-1:0][CNTW-1:0] evcnt;

  wcmp_regs #(.NCH(NCH), .DW(DW), .CNTW(CNTW), .AW(AW), .RW(RW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .en(en), .pp_mode(pp_mode), .amask(amask), .region(region), .hyst(hyst),
    .hi_th(hi_th), .lo_th(lo_th), .evcnt(evcnt), .clr_hi(clr_hi), .clr_lo(clr_lo)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wcmp_chan #(.DW(DW), .CNTW(CNTW)) u_chan (
      .clk(clk), .rst(rst), .en(en),
      .hit(s_valid && (s_chan == CHW'(c))),
      .code(s_code), .hi_th(hi_th[c]), .lo_th(lo_th[c]), .hyst(hyst[c]),
      .evcnt(evcnt[c]), .inband(region[c]), .clr_hi(clr_hi[c]), .clr_lo(clr_lo[c]),
      .flag_hi(flag_hi[c]), .flag_lo(flag_lo[c])
    );
  end

  wcmp_alert #(.NCH(NCH)) u_alert (
    .clk(clk), .rst(rst), .flags_any(flag_hi | flag_lo), .amask(amask),
    .pp_mode(pp_mode), .alert_o(alert_o), .alert_oe(alert_oe)
  );
endmodule

// File: tb/test_wincmp_monitor.sv
`timescale 1ns/1ps
module test_wincmp_monitor;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic [2:0]  s_chan = '0;
  logic [11:0] s_code = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        alert_o, alert_oe;

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  wincmp_monitor i_wincmp_monitor (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_chan(s_chan), .s_code(s_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .alert_o(alert_o), .alert_oe(alert_oe)
  );

  // ---------------- behavioural reference model ----------------
  int m_hi[NCH], m_lo[NCH], m_hy[NCH], m_ev[NCH], m_ch[NCH], m_cl[NCH];
  int m_fh, m_fl, m_amask, m_rg, m_en, m_pp;
  int exp_rd = 0;
  bit exp_o = 0, exp_oe = 0;

  function automatic int mread(int a);
    int c;
    if (a == 0) return m_pp * 2 + m_en;
    if (a == 1) return m_amask;
    if (a == 2) return m_rg;
    if (a == 4) return m_fh;
    if (a == 5) return m_fl;
    if (a == 6) return m_fh | m_fl;
    if (a >= 'h20 && a < 'h40) begin
      c = (a - 'h20) / 4;
      case ((a - 'h20) % 4)
        0: return m_hy[c];
        1: return m_hi[c];
        2: return m_ev[c];
        default: return m_lo[c];
      endcase
    end
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int act, sh, sl, c, code, ch, clh, cll, a, d;
    bit vh, vl;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_hi[i] = 'hFFF; m_lo[i] = 0; m_hy[i] = 0; m_ev[i] = 0; m_ch[i] = 0; m_cl[i] = 0;
      end
      m_fh = 0; m_fl = 0; m_amask = 0; m_rg = 0; m_en = 0; m_pp = 0;
      exp_o = 0; exp_oe = 0; exp_rd = 0;
    end else begin
      act = (((m_fh | m_fl) & m_amask) != 0) ? 1 : 0;
      exp_oe = (m_pp != 0) ? 1'b1 : (act != 0);
      exp_o  = (m_pp != 0) ? (act == 0) : 1'b0;
      exp_rd = mread(int'(rd_addr));
      sh = 0; sl = 0;
      if (m_en == 0) begin
        for (int i = 0; i < NCH; i++) begin m_ch[i] = 0; m_cl[i] = 0; end
      end else if (s_valid) begin
        c = int'(s_chan); code = int'(s_code);
        if (((m_rg >> c) & 1) != 0) begin
          vh = (code >= m_lo[c]) && (code <= m_hi[c]);
          vl = vh;
        end else begin
          vh = (m_ch[c] > 0) ? (code >= m_hi[c] - m_hy[c]) : (code > m_hi[c]);
          vl = (m_cl[c] > 0) ? (code <= m_lo[c] + m_hy[c]) : (code < m_lo[c]);
        end
        if (vh && m_ch[c] >= m_ev[c]) sh = 1 << c;
        if (vl && m_cl[c] >= m_ev[c]) sl = 1 << c;
        ch = m_ch[c] + 1; m_ch[c] = vh ? ((ch > 15) ? 15 : ch) : 0;
        ch = m_cl[c] + 1; m_cl[c] = vl ? ((ch > 15) ? 15 : ch) : 0;
      end
      a = int'(wr_addr); d = int'(wr_data);
      clh = (wr_en && a == 4) ? (d & 'hFF) : 0;
      cll = (wr_en && a == 5) ? (d & 'hFF) : 0;
      m_fh = (sh | (m_fh & ~clh)) & 'hFF;
      m_fl = (sl | (m_fl & ~cll)) & 'hFF;
      if (wr_en) begin
        if (a == 0) begin m_en = d & 1; m_pp = (d >> 1) & 1; end
        else if (a == 1) m_amask = d & 'hFF;
        else if (a == 2) m_rg = d & 'hFF;
        else if (a >= 'h20 && a < 'h40) begin
          c = (a - 'h20) / 4;
          case ((a - 'h20) % 4)
            0: m_hy[c] = d & 'hFFF;
            1: m_hi[c] = d & 'hFFF;
            2: m_ev[c] = d & 'hF;
            default: m_lo[c] = d & 'hFFF;
          endcase
        end
      end
    end
  end

  // Per-clock comparison against the model (R7, R10 on the alert pins, read data)
  always @(negedge clk) begin
    if (started && !rst) begin
      checks++;
      if (alert_o !== exp_o || alert_oe !== exp_oe || int'(rd_data) != exp_rd) begin
        fails++;
        $display("FAIL R7/R10 per-clock model: o=%0b oe=%0b rd=%h expected o=%0b oe=%0b rd=%h",
                 alert_o, alert_oe, rd_data, exp_o, exp_oe, exp_rd[15:0]);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic smp(input int c, input int code);
    @(negedge clk);
    s_valid = 1'b1; s_chan = 3'(c); s_code = 12'(code);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wr_smp(input int a, input int d, input int c, input int code);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 16'(d);
    s_valid = 1'b1; s_chan = 3'(c); s_code = 12'(code);
    @(negedge clk);
    wr_en = 1'b0; s_valid = 1'b0;
  endtask

  task automatic chk_rd(input int a, input int expv, input string tag);
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    checks++;
    if (int'(rd_data) != expv) begin
      fails++;
      $display("FAIL %s: read 0x%h got %h expected %h", tag, a[7:0], rd_data, expv[15:0]);
    end
  endtask

  task automatic chk_alert(input bit eo, input bit eoe, input string tag);
    @(negedge clk);
    checks++;
    if (alert_o !== eo || alert_oe !== eoe) begin
      fails++;
      $display("FAIL %s: alert o=%0b oe=%0b expected o=%0b oe=%0b", tag, alert_o, alert_oe, eo, eoe);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    started = 1'b1;
    // R1 reset state
    chk_alert(1'b0, 1'b0, "R1 alert idle");
    chk_rd('h21, 'hFFF, "R1 high default");
    chk_rd('h23, 0, "R1 low default");
    chk_rd('h20, 0, "R1 hysteresis default");
    chk_rd('h04, 0, "R1 flags clear");
    // R2 disabled: no flags
    wr('h21, 'h800);
    repeat (3) smp(0, 'hF00);
    chk_rd('h04, 0, "R2 disabled no flag");
    wr('h00, 1);
    // R12 defaults never trigger
    smp(1, 'hFFF); smp(1, 0);
    chk_rd('h06, 0, "R12 default thresholds");
    // R4 consecutive count N=2
    wr('h22, 2);
    smp(0, 'h900); smp(0, 'h900); smp(0, 'h100);
    smp(0, 'h900); smp(0, 'h900); smp(1, 'h500);
    chk_rd('h04, 0, "R4 run restarted");
    smp(0, 'h900);
    chk_rd('h04, 1, "R4 third consecutive sets");
    // R8 flag set while masked; R7/R10 alert
    chk_alert(1'b0, 1'b0, "R8 masked flag no alert");
    wr('h01, 1);
    chk_alert(1'b0, 1'b1, "R7 R10 open-drain active");
    wr('h00, 3);
    chk_alert(1'b0, 1'b1, "R10 push-pull active");
    wr('h04, 1);
    chk_rd('h04, 0, "R9 write one clears");
    chk_alert(1'b1, 1'b1, "R10 push-pull idle");
    // R9 set wins over clear
    wr('h22, 0);
    wr_smp('h04, 1, 0, 'h900);
    chk_rd('h04, 1, "R9 set wins");
    wr('h00, 1);
    wr('h04, 1);
    chk_alert(1'b0, 1'b0, "R10 open-drain released");
    // R6 hysteresis high side
    wr('h28, 'h100); wr('h29, 'h800); wr('h2A, 1);
    smp(2, 'h900); smp(2, 'h780);
    wr('h2D, 'h800); wr('h2E, 1);
    smp(3, 'h900); smp(3, 'h780);
    chk_rd('h04, 'h04, "R6 high hysteresis");
    // R6 low side, R5 separate flags
    wr('h30, 'h80); wr('h33, 'h400); wr('h32, 1);
    smp(4, 'h300); smp(4, 'h460);
    chk_rd('h05, 'h10, "R6 low hysteresis");
    chk_rd('h04, 'h04, "R5 low does not set high");
    chk_alert(1'b0, 1'b0, "R7 unmasked flags only");
    wr('h01, 'h10);
    chk_alert(1'b0, 1'b1, "R7 mask selects channel 4");
    // R11 in-band
    wr('h02, 'h60);
    wr('h35, 'h500); wr('h37, 'h300);
    smp(5, 'h400);
    wr('h39, 'h500); wr('h3B, 'h300);
    smp(6, 'h600);
    chk_rd('h04, 'h24, "R11 in-band high flag");
    chk_rd('h05, 'h30, "R11 in-band low flag");
    chk_rd('h06, 'h34, "R13 combined flags");
    // R3 per-channel register layout
    wr('h3C, 'h0AB); wr('h3F, 'h123);
    chk_rd('h3C, 'h0AB, "R3 ch7 hysteresis");
    chk_rd('h3F, 'h123, "R3 ch7 low");
    chk_rd('h3E, 0, "R3 ch7 count");
    chk_rd('h39, 'h500, "R3 ch6 high");
    // R2 disable again
    wr('h00, 0); wr('h04, 'hFF); wr('h05, 'hFF);
    repeat (3) smp(2, 'hF00);
    chk_rd('h06, 0, "R2 disabled after clear");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule